// File: doc/BRIEF.md
# Colour Subcarrier Oscillator with Burst Window

This block produces the running phase of an analog colour subcarrier from a fixed system clock. A phase accumulator of `ACC_W` bits adds a per-standard step on every clock and is never cleared by line or frame events, so the subcarrier phase stays continuous from one line to the next. The step is worked out at elaboration from the exact broadcast ratios and the system clock rate. For NTSC the ratio is 315/88 MHz. For PAL it is (1135/4 + 1/625) times a 15 625 Hz line rate, which is exactly 17 734 475/4 Hz.

A line timer drives the block. Once per line, after the sync pulse ends, the block opens a burst window. The window opens after a programmable number of clocks, which covers the breezeway. It then stays open until a fixed number of whole subcarrier cycles have completed: 9 for NTSC and 10 for PAL. A cycle counts as complete when the accumulator wraps around.

In PAL mode the block also gives a flag that marks the lines on which the V chroma axis is inverted. The flag changes on every line start and returns to zero at the start of each frame. Sine lookup, chroma modulation and the DAC are handled downstream.

Top module: `subcarrier_nco`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it is released before any clock edge has passed, `phase` is 0, `burst_en` is 0 and `v_invert` is 0.
- R2: With `std_pal` = 0, the accumulator grows on every clock edge by round(315e6/88 / CLK_HZ × 2^ACC_W), modulo 2^ACC_W. `phase` shows the top `PHASE_W` bits of the accumulator after that edge.
- R3: With `std_pal` = 1, the step is round(17734475/4 / CLK_HZ × 2^ACC_W). The step used at any edge is the one that `std_pal` selects at that edge.
- R4: `line_start`, `sync_end` and `frame_start` never clear or disturb the accumulator, so `phase` keeps following the sum of steps taken since reset.
- R5: When `sync_end` is sampled high at a clock edge and `burst_delay` = d, `burst_en` stays low for the next d edges and rises on edge d+1. A new `sync_end` restarts this sequence from any state.
- R6: With NTSC latched at `sync_end`, `burst_en` falls on the very edge on which the accumulator completes its 9th wrap after the window opened. A wrap on the opening edge does not count.
- R7: With PAL latched at `sync_end`, the window closes on the 10th such wrap, under the same rules as R6.
- R8: With `std_pal` = 1, every edge with `line_start` high and `frame_start` low inverts `v_invert`.
- R9: An edge with `frame_start` high clears `v_invert`. This takes priority over a `line_start` on the same edge.
- R10: An edge with `std_pal` = 0 clears `v_invert`, and `line_start` has no effect on it in that mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_pal | input | 1 | Standard select: 0 NTSC, 1 PAL |
| line_start | input | 1 | One-clock pulse at the start of each line |
| sync_end | input | 1 | One-clock pulse at the end of horizontal sync |
| frame_start | input | 1 | One-clock pulse at the start of each frame |
| burst_delay | input | DLY_W | Breezeway length in clocks after sync end |
| phase | output | PHASE_W | Top bits of the subcarrier phase accumulator |
| burst_en | output | 1 | High while the colour burst is to be sent |
| v_invert | output | 1 | PAL V-axis inversion for the current line |

## Verification
Every result is registered once. The phase word, the V flag and the burst gate all change on the clock edge that samples their cause, except that the gate opens d+1 edges after `sync_end`. Inputs change on falling edges and outputs are read on the next falling edge, so each reading shows exactly the edges that have passed. A reference accumulator in the bench tracks `phase` on every cycle. The burst windows are measured by counting the phase decreases seen while the gate is open, and the gate must drop on the reading where the last counted decrease appears.

// File: rtl/subcarrier_nco_pkg.sv
package subcarrier_nco_pkg;

   typedef enum logic [1:0] {
      GATE_IDLE = 2'd0,
      GATE_WAIT = 2'd1,
      GATE_OPEN = 2'd2
   } gate_state_e;

   // NTSC subcarrier as num/den Hz: 315e6/88
   localparam logic [63:0] NTSC_NUM = 64'd315_000_000;
   localparam logic [63:0] NTSC_DEN = 64'd88;
   // PAL subcarrier: (1135/4 + 1/625) * 15625 Hz = 17734475/4 Hz
   localparam logic [63:0] PAL_NUM  = 64'd17_734_475;
   localparam logic [63:0] PAL_DEN  = 64'd4;

   // round(num/den / clk_hz * 2^accw), computed in 128-bit integer arithmetic
   function automatic logic [63:0] step_calc(input logic [63:0] num,
                                             input logic [63:0] den,
                                             input logic [63:0] clk_hz,
                                             input int unsigned accw);
      logic [127:0] t;
      logic [127:0] d;
      t = {64'd0, num} << (accw + 1);
      d = {64'd0, den} * {64'd0, clk_hz};
      t = t / d;
      t = (t + 128'd1) >> 1;
      return t[63:0];
   endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
   import subcarrier_nco_pkg::*;
#(
   parameter int unsigned ACC_W   = 32,
   parameter int unsigned PHASE_W = 12,
   parameter longint unsigned CLK_HZ = 27_000_000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               std_pal,
   output logic [PHASE_W-1:0] phase,
   output logic               wrap
);
   localparam logic [63:0] STEP_N64 = step_calc(NTSC_NUM, NTSC_DEN, 64'(CLK_HZ), ACC_W);
   localparam logic [63:0] STEP_P64 = step_calc(PAL_NUM, PAL_DEN, 64'(CLK_HZ), ACC_W);
   localparam logic [ACC_W-1:0] STEP_N = STEP_N64[ACC_W-1:0];
   localparam logic [ACC_W-1:0] STEP_P = STEP_P64[ACC_W-1:0];
   localparam logic [63:0] BUCKET = 64'd1 << (ACC_W - PHASE_W);

   generate
      if (ACC_W < 16 || ACC_W > 48) begin : g_bad_acc
         $error("nco_phase_acc: ACC_W must lie in 16..48");
      end
      if (PHASE_W < 2 || PHASE_W > ACC_W) begin : g_bad_phase
         $error("nco_phase_acc: PHASE_W must lie in 2..ACC_W");
      end
      if (STEP_N64 <= BUCKET || STEP_P64 <= BUCKET) begin : g_bad_step
         $error("nco_phase_acc: step must exceed one phase bucket");
      end
      if (CLK_HZ < 64'd9_000_000) begin : g_bad_clk
         $error("nco_phase_acc: clock below twice the highest subcarrier");
      end
   endgenerate

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] step;
   logic [ACC_W:0]   sum;

   assign step = std_pal ? STEP_P : STEP_N;
   assign sum  = {1'b0, acc_q} + {1'b0, step};
   assign wrap = sum[ACC_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= sum[ACC_W-1:0];
   end

   generate
      if (PHASE_W == ACC_W) begin : g_full
         assign phase = acc_q;
      end else begin : g_slice
         assign phase = acc_q[ACC_W-1 -: PHASE_W];
      end
   endgenerate

   // a carry out must leave the accumulator below its old value (R6 cycle counting)
   assert_wrap_lowers_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (acc_q < $past(acc_q)));
   // without a carry the accumulator never moves backwards (R4 continuity)
   assert_no_backstep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> (acc_q > $past(acc_q)));

endmodule

// File: rtl/burst_window.sv
module burst_window
   import subcarrier_nco_pkg::*;
#(
   parameter int unsigned DLY_W      = 8,
   parameter int unsigned BURST_NTSC = 9,
   parameter int unsigned BURST_PAL  = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             std_pal,
   input  logic             sync_end,
   input  logic [DLY_W-1:0] delay,
   input  logic             wrap,
   output logic             burst_en
);
   localparam int unsigned LEN_MAX = (BURST_PAL > BURST_NTSC) ? BURST_PAL : BURST_NTSC;
   localparam int unsigned CYC_W   = $clog2(LEN_MAX + 1);
   localparam logic [CYC_W-1:0] LEN_N = CYC_W'(BURST_NTSC);
   localparam logic [CYC_W-1:0] LEN_P = CYC_W'(BURST_PAL);

   generate
      if (BURST_NTSC < 1 || BURST_PAL < 1) begin : g_bad_len
         $error("burst_window: burst lengths must be at least one cycle");
      end
      if (DLY_W < 1 || DLY_W > 16) begin : g_bad_dly
         $error("burst_window: DLY_W must lie in 1..16");
      end
   endgenerate

   gate_state_e      st_q;
   logic [DLY_W-1:0] dly_q;
   logic [CYC_W-1:0] cyc_q;
   logic [CYC_W-1:0] len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= GATE_IDLE;
         dly_q <= '0;
         cyc_q <= '0;
         len_q <= '0;
      end else if (sync_end) begin
         st_q  <= GATE_WAIT;
         dly_q <= delay;
         cyc_q <= '0;
         len_q <= std_pal ? LEN_P : LEN_N;
      end else begin
         unique case (st_q)
            GATE_WAIT: begin
               if (dly_q == '0) begin
                  st_q  <= GATE_OPEN;
                  cyc_q <= '0;
               end else begin
                  dly_q <= dly_q - 1'b1;
               end
            end
            GATE_OPEN: begin
               if (wrap) begin
                  if (cyc_q == len_q - 1'b1) st_q <= GATE_IDLE;
                  else                       cyc_q <= cyc_q + 1'b1;
               end
            end
            default: st_q <= GATE_IDLE;
         endcase
      end
   end

   assign burst_en = (st_q == GATE_OPEN);

   // the breezeway expiring opens the window on the next edge
   assert_open_after_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == GATE_WAIT && dly_q == '0 && !sync_end) |=> burst_en);
   // the window only ever closes on a carry out of the accumulator
   assert_close_on_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_en && !wrap && !sync_end) |=> burst_en);
   // completed-cycle count stays below the latched length
   assert_cycle_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      burst_en |-> (cyc_q < len_q));

endmodule

// File: rtl/pal_axis_flag.sv
module pal_axis_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic std_pal,
   input  logic line_start,
   input  logic frame_start,
   output logic v_invert
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      flag_q <= 1'b0;
      else if (frame_start || !std_pal) flag_q <= 1'b0;
      else if (line_start)             flag_q <= ~flag_q;
   end

   assign v_invert = flag_q;

   assert_line_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (std_pal && line_start && !frame_start) |=> (v_invert != $past(v_invert)));
   assert_frame_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !v_invert);
   assert_ntsc_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !std_pal |=> !v_invert);

endmodule

// File: rtl/subcarrier_nco.sv
module subcarrier_nco
   import subcarrier_nco_pkg::*;
#(
   parameter int unsigned     ACC_W      = 32,
   parameter int unsigned     PHASE_W    = 12,
   parameter longint unsigned CLK_HZ     = 27_000_000,
   parameter int unsigned     DLY_W      = 8,
   parameter int unsigned     BURST_NTSC = 9,
   parameter int unsigned     BURST_PAL  = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               std_pal,
   input  logic               line_start,
   input  logic               sync_end,
   input  logic               frame_start,
   input  logic [DLY_W-1:0]   burst_delay,
   output logic [PHASE_W-1:0] phase,
   output logic               burst_en,
   output logic               v_invert
);
   logic wrap;

   nco_phase_acc #(
      .ACC_W   (ACC_W),
      .PHASE_W (PHASE_W),
      .CLK_HZ  (CLK_HZ)
   ) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .std_pal (std_pal),
      .phase   (phase),
      .wrap    (wrap)
   );

   burst_window #(
      .DLY_W      (DLY_W),
      .BURST_NTSC (BURST_NTSC),
      .BURST_PAL  (BURST_PAL)
   ) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .std_pal  (std_pal),
      .sync_end (sync_end),
      .delay    (burst_delay),
      .wrap     (wrap),
      .burst_en (burst_en)
   );

   pal_axis_flag u_flag (
      .clk         (clk),
      .rst_n       (rst_n),
      .std_pal     (std_pal),
      .line_start  (line_start),
      .frame_start (frame_start),
      .v_invert    (v_invert)
   );

   // a fresh sync end always closes any open window on the next edge (R5)
   assert_restart_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sync_end |=> !burst_en);

endmodule

// File: tb/subcarrier_nco_test.sv
`timescale 1ns/1ps
module subcarrier_nco_test;
   localparam int unsigned ACC_W   = 32;
   localparam int unsigned PHASE_W = 12;
   localparam longint unsigned CLK_HZ = 27_000_000;
   localparam int unsigned DLY_W   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic std_pal = 1'b0, line_start = 1'b0, sync_end = 1'b0, frame_start = 1'b0;
   logic [DLY_W-1:0]   burst_delay = '0;
   logic [PHASE_W-1:0] phase;
   logic burst_en, v_invert;

   int tests = 0, fails = 0, phase_err = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   subcarrier_nco #(.ACC_W(ACC_W), .PHASE_W(PHASE_W), .CLK_HZ(CLK_HZ), .DLY_W(DLY_W)) uut (
      .clk(clk), .rst_n(rst_n), .std_pal(std_pal), .line_start(line_start),
      .sync_end(sync_end), .frame_start(frame_start), .burst_delay(burst_delay),
      .phase(phase), .burst_en(burst_en), .v_invert(v_invert));

   // reference accumulator built from the step formulas of R2/R3
   longint step_n, step_p;
   longint ref_acc = 0;
   initial begin
      step_n = longint'((315.0e6 / 88.0) / real'(CLK_HZ) * 4294967296.0);
      step_p = longint'((17734475.0 / 4.0) / real'(CLK_HZ) * 4294967296.0);
   end
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) ref_acc <= 0;
      else ref_acc <= (ref_acc + (std_pal ? step_p : step_n)) & 64'hFFFF_FFFF;
   end
   always @(negedge clk) begin
      if (rst_n && phase != PHASE_W'(ref_acc >> (ACC_W - PHASE_W))) phase_err++;
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // pulse sync_end, then measure the window (R5, R6, R7)
   task automatic run_burst(input bit pal, input int d, input int len, input string req);
      int wraps;
      int guard;
      bit ok_low;
      logic [PHASE_W-1:0] prev;
      @(negedge clk);
      std_pal = pal; burst_delay = DLY_W'(d); sync_end = 1'b1;
      @(negedge clk);
      sync_end = 1'b0;
      ok_low = 1'b1;
      for (int i = 0; i < d; i++) begin
         if (burst_en) ok_low = 1'b0;
         @(negedge clk);
      end
      if (burst_en) ok_low = 1'b0;
      @(negedge clk);
      check(ok_low && burst_en, "R5 window opens on edge d+1", burst_en, 1);
      prev = phase; wraps = 0; guard = 0;
      while (burst_en && guard < 500) begin
         @(negedge clk);
         guard++;
         if (phase < prev) wraps++;
         if (!burst_en) begin
            check(wraps == len, req, wraps, len);
            check(phase < prev, {req, " closes on a wrap"}, phase, prev);
         end
         prev = phase;
      end
      check(guard < 500, {req, " window ended"}, guard, 0);
   endtask

   // {std_pal, delay[7:0], length[3:0]}
   localparam logic [12:0] VEC [8] = '{
      {1'b0, 8'd0,   4'd9},
      {1'b1, 8'd0,   4'd10},
      {1'b0, 8'd5,   4'd9},
      {1'b1, 8'd17,  4'd10},
      {1'b0, 8'd40,  4'd9},
      {1'b1, 8'd3,   4'd10},
      {1'b0, 8'd1,   4'd9},
      {1'b1, 8'd255, 4'd10}
   };

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(phase == 0 && !burst_en && !v_invert, "R1 reset state",
            {phase, burst_en, v_invert}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(phase == PHASE_W'(step_n >> (ACC_W - PHASE_W)), "R2 first NTSC step",
            phase, step_n >> (ACC_W - PHASE_W));

      // table walk: R5, R6, R7
      foreach (VEC[k]) begin
         run_burst(VEC[k][12], int'(VEC[k][11:4]), int'(VEC[k][3:0]),
                   VEC[k][12] ? "R7 PAL burst length" : "R6 NTSC burst length");
      end

      // R5 restart while open: new sync_end closes window then reopens
      @(negedge clk); std_pal = 1'b0; burst_delay = 8'd0; sync_end = 1'b1;
      @(negedge clk); sync_end = 1'b0;
      @(negedge clk);
      check(burst_en, "R5 open before restart", burst_en, 1);
      sync_end = 1'b1; burst_delay = 8'd2;
      @(negedge clk); sync_end = 1'b0;
      check(!burst_en, "R5 restart closes window", burst_en, 0);
      repeat (2) @(negedge clk);
      check(!burst_en, "R5 restart waits delay", burst_en, 0);
      @(negedge clk);
      check(burst_en, "R5 restart reopens", burst_en, 1);
      repeat (120) @(negedge clk);

      // R8 / R9 PAL axis flag
      std_pal = 1'b1; frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
      check(!v_invert, "R9 frame start clears", v_invert, 0);
      for (int n = 1; n <= 5; n++) begin
         line_start = 1'b1;
         @(negedge clk); line_start = 1'b0;
         check(v_invert == n[0], "R8 toggle per line", v_invert, n[0]);
         repeat (3) @(negedge clk);
      end
      check(v_invert == 1'b1, "R8 flag holds between lines", v_invert, 1);
      frame_start = 1'b1; line_start = 1'b1;
      @(negedge clk); frame_start = 1'b0; line_start = 1'b0;
      check(!v_invert, "R9 frame beats line start", v_invert, 0);
      line_start = 1'b1;
      @(negedge clk); line_start = 1'b0;
      check(v_invert, "R8 toggles after frame", v_invert, 1);

      // R10 NTSC clears and ignores line_start
      std_pal = 1'b0;
      @(negedge clk);
      check(!v_invert, "R10 NTSC clears flag", v_invert, 0);
      line_start = 1'b1;
      @(negedge clk); line_start = 1'b0;
      check(!v_invert, "R10 NTSC ignores line start", v_invert, 0);

      // R4 phase continuity through all events; R3 PAL step tracking
      std_pal = 1'b1;
      for (int n = 0; n < 200; n++) begin
         line_start = (n % 7 == 0); sync_end = (n % 11 == 0); frame_start = (n % 50 == 0);
         @(negedge clk);
      end
      line_start = 1'b0; sync_end = 1'b0; frame_start = 1'b0;
      check(phase_err == 0, "R3 PAL step and R2 NTSC step tracking", phase_err, 0);
      std_pal = 1'b0;
      repeat (100) @(negedge clk);
      check(phase_err == 0, "R4 phase continuous across line events", phase_err, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule